// File: doc/BRIEF.md
# Per-Area Bus Wait-State Sequencer

This block decides how many bus states each access lasts and then paces them. A bus master raises `start` with the target area number (0 to 7), the direction, and the current wait configuration. The sequencer then holds `busy` high for one clock per bus state. It pulses `done` in the final state. If the access uses a setting that is not allowed, it also pulses `err` in that final state.

The length of an access depends on its area class. On-chip memory, on-chip peripherals, multiplexed I/O, DRAM column cycles, ordinary external memory and long-wait external memory each follow their own rule. Some classes have a fixed length and never look at the external wait input. Others add a programmable long wait, or keep adding states while the external wait input is low. The whole configuration is taken at the start of an access, so a later change only affects later accesses.

Top module: `bwait_seq`

## Requirements
- R1: With `int_space` high, an access to area 0 or area 7 lasts exactly 1 state, whatever `wait_n` does.
- R2: With `int_space` high, an access to area 5 lasts exactly 3 states, whatever `wait_n` does.
- R3: An access to area 6 with `mux6_en` high lasts at least 4 states and always honours `wait_n`.
- R4: A read from area 1 (with `dram1_en` low) or from areas 3, 4, 5 or 7 (with `int_space` low) lasts 1 state with `wait_n` ignored when `wait_en[area]` is 0. It lasts 2 states plus wait states when that bit is 1.
- R5: Areas 0 and 2 (`int_space` low) and area 6 (`mux6_en` low) last 1 + (`lw_sel` + 1) base states. `wait_n` is honoured on writes, and on reads when `wait_en[area]` is 1.
- R6: Area 1 with `dram1_en` high lasts 1 state with `wait_n` ignored when `wait_en[1]` is 0, and 2 states plus wait states when it is 1, in either direction.
- R7: A write to area 1 (with `dram1_en` low) and `wr1_wait` low is prohibited. It still lasts exactly 2 states, and `err` is high only in its final state, alongside `done`. With `wr1_wait` high the write lasts 2 states plus wait states and `err` stays low.
- R8: A write to areas 3, 4, 5 or 7 (`int_space` low) lasts 2 states plus wait states, regardless of `wait_en`.
- R9: When an access honours `wait_n`, the input is sampled only from its final base state onward. Each sample that finds `wait_n` low adds one more state. A low level during earlier states has no effect.
- R10: `start` is accepted when the sequencer is idle or in the cycle that asserts `done`, and the first state follows in the next cycle. At any other time `start` is ignored.
- R11: Area, direction and every configuration input are captured when an access is accepted. Changes during an access do not alter its length or its error result.
- R12: After reset `busy`, `done` and `err` are low. `busy` stays high without a gap for every state of an access, and `done` is high only in its last state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request for a new access |
| area | input | 3 | Target area number |
| wr | input | 1 | 1 = write, 0 = read |
| int_space | input | 1 | Areas 0, 7 address on-chip memory and area 5 addresses on-chip peripherals |
| dram1_en | input | 1 | Area 1 is DRAM |
| mux6_en | input | 1 | Area 6 is multiplexed I/O |
| wait_en | input | 8 | Per-area wait-enable bits, indexed by area number |
| wr1_wait | input | 1 | Write-wait enable for area 1 |
| lw_sel | input | LW_W (2) | Long-wait count; value v gives v+1 extra states |
| wait_n | input | 1 | External wait request, active low |
| busy | output | 1 | High during each bus state |
| done | output | 1 | High in the final state of an access |
| err | output | 1 | High in the final state of a prohibited access |

## Verification
A table of vectors covers every area class in both directions. Each vector sets only the selected area's wait-enable bit, or clears only that bit, so a wrong bit index gives a different length. Each vector also holds `wait_n` low for a chosen number of leading states. An access that ignores the input keeps its base length, and one that honours it stretches to exactly one state past the last low sample. A short low window placed before the final base state shows that early samples are not taken. Directed runs change the configuration and raise `start` in the middle of an access, and they chain two accesses through the `done` cycle. These runs separate capture at start from live decoding, and acceptance in the `done` cycle from acceptance only when idle.

// File: rtl/bwait_pkg.sv
package bwait_pkg;

   localparam int AREA_W  = 3;
   localparam int N_AREAS = 1 << AREA_W;

   typedef enum logic [2:0] {
      CLS_ONCHIP = 3'd0,
      CLS_PERIPH = 3'd1,
      CLS_MUXIO  = 3'd2,
      CLS_DRAM   = 3'd3,
      CLS_EXT1   = 3'd4,
      CLS_EXTS   = 3'd5,
      CLS_EXTL   = 3'd6
   } area_cls_e;

   // Class of one area, given the mapping flags.
   function automatic area_cls_e map_area(input int idx, input logic ints,
                                          input logic dram, input logic mux);
      area_cls_e c;
      case (idx)
         0:       c = ints ? CLS_ONCHIP : CLS_EXTL;
         1:       c = dram ? CLS_DRAM   : CLS_EXT1;
         2:       c = CLS_EXTL;
         5:       c = ints ? CLS_PERIPH : CLS_EXTS;
         6:       c = mux  ? CLS_MUXIO  : CLS_EXTL;
         7:       c = ints ? CLS_ONCHIP : CLS_EXTS;
         default: c = CLS_EXTS;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/bwait_areamap.sv
module bwait_areamap
   import bwait_pkg::*;
(
   input  logic [AREA_W-1:0] area,
   input  logic              int_space,
   input  logic              dram1_en,
   input  logic              mux6_en,
   output area_cls_e         cls
);

   area_cls_e cls_v [N_AREAS];

   for (genvar g = 0; g < N_AREAS; g++) begin : g_area
      assign cls_v[g] = map_area(g, int_space, dram1_en, mux6_en);
   end

   assign cls = cls_v[area];

endmodule

// File: rtl/bwait_timing.sv
module bwait_timing
   import bwait_pkg::*;
#(
   parameter int LW_W        = 2,
   parameter int MUX_BASE    = 4,
   parameter int PERIPH_BASE = 3,
   parameter int CNT_W       = 3
)(
   input  area_cls_e        cls,
   input  logic             wr,
   input  logic             wbit,
   input  logic             wr1_wait,
   input  logic [LW_W-1:0]  lw_sel,
   output logic [CNT_W-1:0] base_m1,
   output logic             honour,
   output logic             bad
);

   localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
   localparam logic [CNT_W-1:0] PER_M1 = CNT_W'(PERIPH_BASE - 1);
   localparam logic [CNT_W-1:0] MUX_M1 = CNT_W'(MUX_BASE - 1);

   always_comb begin
      base_m1 = '0;
      honour  = 1'b0;
      bad     = 1'b0;
      case (cls)
         CLS_ONCHIP: base_m1 = '0;
         CLS_PERIPH: base_m1 = PER_M1;
         CLS_MUXIO: begin
            base_m1 = MUX_M1;
            honour  = 1'b1;
         end
         CLS_DRAM: begin
            if (wbit) begin
               base_m1 = ONE;
               honour  = 1'b1;
            end
         end
         CLS_EXT1: begin
            if (wr) begin
               base_m1 = ONE;
               honour  = wr1_wait;
               bad     = ~wr1_wait;
            end else if (wbit) begin
               base_m1 = ONE;
               honour  = 1'b1;
            end
         end
         CLS_EXTS: begin
            if (wr || wbit) begin
               base_m1 = ONE;
               honour  = 1'b1;
            end
         end
         CLS_EXTL: begin
            base_m1 = CNT_W'(lw_sel) + ONE;
            honour  = wr | wbit;
         end
         default: base_m1 = '0;
      endcase
   end

endmodule

// File: rtl/bwait_ctrl.sv
module bwait_ctrl #(
   parameter int CNT_W = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] base_m1,
   input  logic             honour,
   input  logic             bad,
   input  logic             wait_n,
   output logic             busy,
   output logic             done,
   output logic             err
);

   logic             busy_q;
   logic [CNT_W-1:0] rem_q;
   logic             hon_q;
   logic             bad_q;
   logic             last_base;
   logic             fin;
   logic             accept;

   assign last_base = (rem_q == '0);
   assign fin       = busy_q & last_base & (~hon_q | wait_n);
   assign accept    = start & (~busy_q | fin);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         rem_q  <= '0;
         hon_q  <= 1'b0;
         bad_q  <= 1'b0;
      end else if (accept) begin
         busy_q <= 1'b1;
         rem_q  <= base_m1;
         hon_q  <= honour;
         bad_q  <= bad;
      end else if (fin) begin
         busy_q <= 1'b0;
      end else if (busy_q && !last_base) begin
         rem_q  <= rem_q - CNT_W'(1);
      end
   end

   assign busy = busy_q;
   assign done = fin;
   assign err  = fin & bad_q;

endmodule

// File: rtl/bwait_seq.sv
module bwait_seq
   import bwait_pkg::*;
#(
   parameter int LW_W        = 2,
   parameter int MUX_BASE    = 4,
   parameter int PERIPH_BASE = 3
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [AREA_W-1:0]  area,
   input  logic               wr,
   input  logic               int_space,
   input  logic               dram1_en,
   input  logic               mux6_en,
   input  logic [N_AREAS-1:0] wait_en,
   input  logic               wr1_wait,
   input  logic [LW_W-1:0]    lw_sel,
   input  logic               wait_n,
   output logic               busy,
   output logic               done,
   output logic               err
);

   localparam int LONG_BASE = 1 + (1 << LW_W);
   localparam int MAX_A     = (LONG_BASE > MUX_BASE) ? LONG_BASE : MUX_BASE;
   localparam int MAX_BASE  = (MAX_A > PERIPH_BASE) ? MAX_A : PERIPH_BASE;
   localparam int CNT_W     = $clog2(MAX_BASE);

   if (LW_W < 1 || LW_W > 4) begin : g_bad_lw
      $error("bwait_seq: LW_W must lie in 1..4");
   end
   if (MUX_BASE < 2) begin : g_bad_mux
      $error("bwait_seq: MUX_BASE must be at least 2");
   end
   if (PERIPH_BASE < 1) begin : g_bad_per
      $error("bwait_seq: PERIPH_BASE must be at least 1");
   end

   area_cls_e        cls;
   logic [CNT_W-1:0] base_m1;
   logic             honour;
   logic             bad;

   bwait_areamap u_map (
      .area      (area),
      .int_space (int_space),
      .dram1_en  (dram1_en),
      .mux6_en   (mux6_en),
      .cls       (cls)
   );

   bwait_timing #(
      .LW_W        (LW_W),
      .MUX_BASE    (MUX_BASE),
      .PERIPH_BASE (PERIPH_BASE),
      .CNT_W       (CNT_W)
   ) u_timing (
      .cls      (cls),
      .wr       (wr),
      .wbit     (wait_en[area]),
      .wr1_wait (wr1_wait),
      .lw_sel   (lw_sel),
      .base_m1  (base_m1),
      .honour   (honour),
      .bad      (bad)
   );

   bwait_ctrl #(
      .CNT_W (CNT_W)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .base_m1 (base_m1),
      .honour  (honour),
      .bad     (bad),
      .wait_n  (wait_n),
      .busy    (busy),
      .done    (done),
      .err     (err)
   );

endmodule

// File: rtl/bwait_seq_chk.sv
module bwait_seq_chk
   import bwait_pkg::*;
#(
   parameter int LW_W = 2
)(
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic [AREA_W-1:0]  area,
   input logic               wr,
   input logic               int_space,
   input logic               dram1_en,
   input logic               mux6_en,
   input logic [N_AREAS-1:0] wait_en,
   input logic               wr1_wait,
   input logic [LW_W-1:0]    lw_sel,
   input logic               wait_n,
   input logic               busy,
   input logic               done,
   input logic               err
);

   logic ready;
   assign ready = !busy || done;

   AST_DONE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy) else $error("done outside access"); // R12

   AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy) else $error("busy dropped early"); // R12

   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done) else $error("err away from done"); // R7

   AST_ONCHIP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ready && int_space && (area == 3'd0 || area == 3'd7)) |=> (busy && done))
      else $error("on-chip access not single state"); // R1

   AST_PERIPH_THREE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ready && int_space && area == 3'd5) |=> (!done ##1 !done ##1 done))
      else $error("peripheral access not three states"); // R2

   AST_MUX_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ready && mux6_en && area == 3'd6) |=> (!done ##1 !done ##1 !done))
      else $error("mux access shorter than four"); // R3

   AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !busy) else $error("busy after final state"); // R10

   AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy) else $error("idle start not accepted"); // R10

endmodule

bind bwait_seq bwait_seq_chk #(.LW_W(LW_W)) u_chk (.*);

// File: tb/bwait_seq_test.sv
`timescale 1ns/1ps
module bwait_seq_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       start;
   logic [2:0] area;
   logic       wr;
   logic       int_space;
   logic       dram1_en;
   logic       mux6_en;
   logic [7:0] wait_en;
   logic       wr1_wait;
   logic [1:0] lw_sel;
   logic       wait_n;
   logic       busy;
   logic       done;
   logic       err;

   int nchk = 0;
   int nerr = 0;

   always #4 clk = ~clk;

   bwait_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .area(area), .wr(wr),
      .int_space(int_space), .dram1_en(dram1_en), .mux6_en(mux6_en),
      .wait_en(wait_en), .wr1_wait(wr1_wait), .lw_sel(lw_sel),
      .wait_n(wait_n), .busy(busy), .done(done), .err(err)
   );

   typedef struct packed {
      logic [2:0] area;
      logic       wr;
      logic       ints;
      logic       dram;
      logic       mux;
      logic       wbit;
      logic       ww;
      logic [1:0] lw;
      logic [3:0] wlow;
      logic [3:0] len;
      logic       err;
   } vec_t;

   //                area  wr    ints  dram  mux   wbit  ww    lw    wlow  len   err
   localparam vec_t VEC [18] = '{
      '{3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 4'd3, 4'd1, 1'b0},  // R1
      '{3'd7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 4'd3, 4'd1, 1'b0},  // R1
      '{3'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 4'd5, 4'd3, 1'b0},  // R2
      '{3'd6, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 4'd0, 4'd4, 1'b0},  // R3
      '{3'd6, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 4'd6, 4'd7, 1'b0},  // R3
      '{3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 4'd4, 4'd1, 1'b0},  // R4
      '{3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 4'd0, 4'd2, 1'b0},  // R4
      '{3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 4'd3, 4'd4, 1'b0},  // R4
      '{3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 4'd9, 4'd4, 1'b0},  // R5
      '{3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 4'd6, 4'd7, 1'b0},  // R5
      '{3'd6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd2, 4'd3, 1'b0},  // R5
      '{3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 4'd4, 4'd1, 1'b0},  // R6
      '{3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 4'd2, 4'd3, 1'b0},  // R6
      '{3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 4'd5, 4'd2, 1'b1},  // R7
      '{3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 4'd1, 4'd2, 1'b0},  // R7, R9
      '{3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd3, 4'd4, 1'b0},  // R8
      '{3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd0, 4'd2, 1'b0},  // R8
      '{3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 4'd2, 4'd3, 1'b0}   // R4
   };

   function automatic string tag_of(input int i);
      case (i)
         0, 1:        return "R1";
         2:           return "R2";
         3, 4:        return "R3";
         5, 6, 7, 17: return "R4";
         8, 9, 10:    return "R5";
         11, 12:      return "R6";
         13:          return "R7";
         14:          return "R7/R9";
         default:     return "R8";
      endcase
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      area      = v.area;
      wr        = v.wr;
      int_space = v.ints;
      dram1_en  = v.dram;
      mux6_en   = v.mux;
      wait_en   = v.wbit ? (8'b1 << v.area) : ~(8'b1 << v.area);
      wr1_wait  = v.ww;
      lw_sel    = v.lw;
   endtask

   // Called at a negedge after start was raised; walks states until done.
   task automatic measure(input int wlow, input int chg_at,
                          output int len, output int errs, output int err_last);
      int s;
      s = 0; len = 0; errs = 0; err_last = 0;
      while (len == 0 && s < 40) begin
         @(negedge clk);
         start  = 1'b0;
         s++;
         wait_n = (s > wlow);
         if (s == chg_at) begin
            area = 3'd5; int_space = 1'b1; lw_sel = 2'd0;
            wait_en = 8'hff; wr = 1'b1; start = 1'b1;
         end
         #1;
         if (!busy) len = 100 + s;
         else if (done) begin
            len = s;
            err_last = int'(err);
         end
         if (err) errs++;
      end
      wait_n = 1'b1;
   endtask

   initial begin
      #(8 * 20000);
      nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      int len, errs, el;
      rst_n = 1'b0; start = 1'b0; wait_n = 1'b1;
      area = '0; wr = 1'b0; int_space = 1'b0; dram1_en = 1'b0; mux6_en = 1'b0;
      wait_en = '0; wr1_wait = 1'b0; lw_sel = '0;
      repeat (3) @(negedge clk);
      #1;
      chk("R12", "reset busy", int'(busy), 0);
      chk("R12", "reset done", int'(done), 0);
      chk("R12", "reset err", int'(err), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk("R12", "idle busy without start", int'(busy), 0);

      for (int i = 0; i < 18; i++) begin
         @(negedge clk);
         apply(VEC[i]);
         start = 1'b1;
         measure(int'(VEC[i].wlow), 0, len, errs, el);
         chk(tag_of(i), "length", len, int'(VEC[i].len));
         chk(tag_of(i), "err pulses", errs, int'(VEC[i].err));
         chk(tag_of(i), "err at done", el, int'(VEC[i].err));
      end

      // R11 and R10: long-wait access (5 states, wait ignored); config scrambled
      // and start raised in state 2 must change nothing.
      @(negedge clk);
      apply('{3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 4'd15, 4'd5, 1'b0});
      start = 1'b1;
      measure(15, 2, len, errs, el);
      chk("R11", "length after mid-access change", len, 5);
      chk("R11", "err after mid-access change", errs, 0);
      @(negedge clk);
      #1;
      chk("R10", "start during access ignored", int'(busy), 0);

      // R10: back-to-back through the done cycle.
      @(negedge clk);
      apply('{3'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd0, 4'd3, 1'b0});
      start = 1'b1;
      measure(0, 0, len, errs, el);
      chk("R10", "first of chained pair", len, 3);
      apply('{3'd6, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 4'd0, 4'd4, 1'b0});
      start = 1'b1;
      measure(0, 0, len, errs, el);
      chk("R10", "second of chained pair", len, 4);

      // R9: mux access, wait low only in states 1..2, then high: base length kept.
      @(negedge clk);
      apply('{3'd6, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 4'd2, 4'd4, 1'b0});
      start = 1'b1;
      measure(2, 0, len, errs, el);
      chk("R9", "early wait not sampled", len, 4);

      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

endmodule